// File: doc/BRIEF.md
# I2C Clock-Low Timeout Monitor

This block sits next to an I2C master bit engine. Its job is to catch a remote target that stretches the clock far beyond what the system accepts. Software programs an 8-bit limit. At every START the block loads a 12-bit down-counter with that limit in the upper eight bits and zeros in the lower four. The counter then steps down once on each strobe that marks a falling edge of the master's internal bit-rate clock. That internal clock keeps running at the configured rate even while the wire SCL is held low, so the count measures the total allowed time of a transaction rather than the level on the line.

When the count runs out, the block does three things. It sets a sticky timeout status bit and a raw interrupt flag. It also asks the bit engine to abort with a STOP, and it raises that request only while both SCL and SDA read high, that is, while the bus is released. The timeout status clears when the engine reports the STOP. The raw flag stays set until software writes 1 to clear it. The interrupt output is the raw flag gated by an enable bit. A bus-monitor register returns the present levels of SCL and SDA.

The register port is a plain write strobe with an address and write data. Read data is combinational from the address. Register map (3-bit address):
- Address 0: limit (read/write).
- Address 1: status, with bit 0 = timeout, bit 1 = counting, bit 2 = abort request.
- Address 2: raw flag in bit 0. Write 1 to clear it.
- Address 3: interrupt enable in bit 0.
- Address 4: bus monitor, with bit 0 = SCL and bit 1 = SDA.

Top module: `ckto_monitor`

## Requirements
- R1: The limit register at address 0 accepts any 8-bit write at any time, including before the first START after reset, and reads back exactly the value written.
- R2: For a limit L of 2 or more, expiry happens on exactly the (L*16)-th tick after START, and not earlier. For example, L=0xDA expires on tick 3488. Expiry sets status bit 0 and raw flag bit 0.
- R3: A limit of 0x00 or 0x01 disables the timeout. A START then leaves the counter idle (status bit 1 = 0), and no expiry occurs however many ticks follow.
- R4: The count advances only on tick strobes between a START and a STOP. The level of SCL has no effect on it. Ticks while idle are not counted.
- R5: A limit written during a transaction does not change the countdown in progress. It takes effect at the next START.
- R6: The timeout status bit clears on a STOP event, while the raw flag stays set.
- R7: The abort request is high only while the timeout status is set and both SCL and SDA are high. It drops after the STOP event.
- R8: Writing 1 to bit 0 at address 2 clears the raw flag. Writing 0 there leaves it unchanged.
- R9: The irq output equals the raw flag ANDed with bit 0 at address 3.
- R10: Address 4 returns the instantaneous SCL level in bit 0 and SDA level in bit 1.
- R11: After reset, all of the following read as zero: limit, status, raw flag, enable, irq and abort request.
- R12: A START that arrives while a countdown is running reloads the full count from the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset (master reset) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| start_evt | input | 1 | One-cycle strobe: START issued |
| stop_evt | input | 1 | One-cycle strobe: STOP issued |
| bit_tick | input | 1 | Falling edge strobe of the internal bit clock |
| scl_in | input | 1 | Raw SCL level |
| sda_in | input | 1 | Raw SDA level |
| abort_req | output | 1 | Request to the engine to abort with a STOP |
| irq | output | 1 | Masked timeout interrupt |

## Verification
The hardest situation to reach is an expiry on the exact boundary tick, combined with a stalled bus. It needs thousands of tick strobes with SCL held low, and in the same transaction the limit must be rewritten or the START repeated. The bench sweeps every limit from 0 to 20, plus 0xDA and 0xFF. Ticks are driven back to back with SCL low. The bench checks status one tick before the expected expiry and again on the expiry tick. It then releases SCL and SDA separately to observe the abort request. Separate runs interleave limit rewrites, repeated STARTs and idle ticks, so the tick at which expiry lands is fixed arithmetically from the requirements.

// File: rtl/ckto_pkg.sv
package ckto_pkg;
   // register select codes; offsets are fixed by the address map
   typedef enum logic [2:0] {
      SEL_LIMIT = 3'd0,
      SEL_STAT  = 3'd1,
      SEL_RAW   = 3'd2,
      SEL_IEN   = 3'd3,
      SEL_BMON  = 3'd4
   } ckto_sel_e;

   // status field positions
   localparam int ST_TIMEOUT = 0;
   localparam int ST_ACTIVE  = 1;
   localparam int ST_ABORT   = 2;
   localparam int ST_BITS    = 3;
endpackage

// File: rtl/ckto_counter.sv
module ckto_counter #(
   parameter int CNT_W   = 8,
   parameter int FRAC_W  = 4,
   parameter int MIN_LIM = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start_evt,
   input  logic                      stop_evt,
   input  logic                      bit_tick,
   input  logic [CNT_W-1:0]          limit,
   output logic [CNT_W+FRAC_W-1:0]   cnt,
   output logic                      active,
   output logic                      expire
);
   localparam int TOT_W = CNT_W + FRAC_W;

   logic [TOT_W-1:0] load_val;
   logic             lim_ok;
   logic             last_tick;

   assign load_val  = {limit, {FRAC_W{1'b0}}};
   assign lim_ok    = (limit >= CNT_W'(MIN_LIM));
   assign last_tick = (cnt == TOT_W'(1));

   // expiry: final tick of a running count, with no START/STOP overriding it
   assign expire = active && bit_tick && last_tick && !start_evt && !stop_evt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         active <= 1'b0;
      end else if (stop_evt) begin
         active <= 1'b0;
      end else if (start_evt) begin
         cnt    <= load_val;
         active <= lim_ok;
      end else if (active && bit_tick) begin
         cnt <= cnt - TOT_W'(1);
         if (last_tick) begin
            active <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/ckto_abort.sv
module ckto_abort #(
   parameter bit ABORT_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic expire,
   input  logic stop_evt,
   input  logic scl_in,
   input  logic sda_in,
   output logic to_stat,
   output logic abort_req
);
   logic bus_free;
   assign bus_free = scl_in && sda_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         to_stat <= 1'b0;
      end else if (stop_evt) begin
         to_stat <= 1'b0;
      end else if (expire) begin
         to_stat <= 1'b1;
      end
   end

   generate
      if (ABORT_REG) begin : g_abort_reg
         logic abort_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               abort_q <= 1'b0;
            end else begin
               abort_q <= to_stat && bus_free && !stop_evt;
            end
         end
         assign abort_req = abort_q;
      end else begin : g_abort_comb
         assign abort_req = to_stat && bus_free;
      end
   endgenerate
endmodule

// File: rtl/ckto_regs.sv
module ckto_regs
   import ckto_pkg::*;
#(
   parameter int CNT_W  = 8,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [CNT_W-1:0]  reg_wdata,
   input  logic              expire,
   input  logic              to_stat,
   input  logic              active,
   input  logic              abort_req,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic [CNT_W-1:0]  limit,
   output logic              raw,
   output logic              ien,
   output logic [CNT_W-1:0]  reg_rdata
);
   logic hit_limit, hit_stat, hit_raw, hit_ien, hit_bmon;

   assign hit_limit = (reg_addr == ADDR_W'(SEL_LIMIT));
   assign hit_stat  = (reg_addr == ADDR_W'(SEL_STAT));
   assign hit_raw   = (reg_addr == ADDR_W'(SEL_RAW));
   assign hit_ien   = (reg_addr == ADDR_W'(SEL_IEN));
   assign hit_bmon  = (reg_addr == ADDR_W'(SEL_BMON));

   logic [ST_BITS-1:0] stat_vec;
   always_comb begin
      stat_vec             = '0;
      stat_vec[ST_TIMEOUT] = to_stat;
      stat_vec[ST_ACTIVE]  = active;
      stat_vec[ST_ABORT]   = abort_req;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         limit <= '0;
         ien   <= 1'b0;
      end else if (reg_wr) begin
         if (hit_limit) limit <= reg_wdata;
         if (hit_ien)   ien   <= reg_wdata[0];
      end
   end

   // set has priority over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw <= 1'b0;
      end else if (expire) begin
         raw <= 1'b1;
      end else if (reg_wr && hit_raw && reg_wdata[0]) begin
         raw <= 1'b0;
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (hit_limit)     reg_rdata = limit;
      else if (hit_stat) reg_rdata = CNT_W'(stat_vec);
      else if (hit_raw)  reg_rdata = CNT_W'(raw);
      else if (hit_ien)  reg_rdata = CNT_W'(ien);
      else if (hit_bmon) reg_rdata = CNT_W'({sda_in, scl_in});
   end
endmodule

// File: rtl/ckto_monitor.sv
module ckto_monitor #(
   parameter int CNT_W     = 8,
   parameter int FRAC_W    = 4,
   parameter int MIN_LIM   = 2,
   parameter int ADDR_W    = 3,
   parameter bit ABORT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [CNT_W-1:0]  reg_wdata,
   output logic [CNT_W-1:0]  reg_rdata,
   input  logic              start_evt,
   input  logic              stop_evt,
   input  logic              bit_tick,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              abort_req,
   output logic              irq
);
   localparam int TOT_W = CNT_W + FRAC_W;

   generate
      if (CNT_W < ckto_pkg::ST_BITS) begin : g_bad_cnt
         $error("CNT_W too narrow for status fields");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("ADDR_W must cover five registers");
      end
      if (MIN_LIM < 1 || MIN_LIM >= (1 << CNT_W)) begin : g_bad_min
         $error("MIN_LIM out of range");
      end
   endgenerate

   logic [CNT_W-1:0] limit;
   logic [TOT_W-1:0] cnt;
   logic             active, expire, to_stat, raw, ien;

   ckto_counter #(.CNT_W(CNT_W), .FRAC_W(FRAC_W), .MIN_LIM(MIN_LIM)) u_cnt (
      .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
      .bit_tick(bit_tick), .limit(limit), .cnt(cnt), .active(active), .expire(expire)
   );

   ckto_abort #(.ABORT_REG(ABORT_REG)) u_abt (
      .clk(clk), .rst_n(rst_n), .expire(expire), .stop_evt(stop_evt),
      .scl_in(scl_in), .sda_in(sda_in), .to_stat(to_stat), .abort_req(abort_req)
   );

   ckto_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .expire(expire), .to_stat(to_stat), .active(active),
      .abort_req(abort_req), .scl_in(scl_in), .sda_in(sda_in), .limit(limit),
      .raw(raw), .ien(ien), .reg_rdata(reg_rdata)
   );

   assign irq = raw && ien;
endmodule

// File: rtl/ckto_monitor_chk.sv
module ckto_monitor_chk #(
   parameter int CNT_W     = 8,
   parameter int FRAC_W    = 4,
   parameter int MIN_LIM   = 2,
   parameter int ADDR_W    = 3,
   parameter bit ABORT_REG = 1'b0
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    start_evt,
   input logic                    stop_evt,
   input logic                    bit_tick,
   input logic                    scl_in,
   input logic                    sda_in,
   input logic                    reg_wr,
   input logic [ADDR_W-1:0]       reg_addr,
   input logic [CNT_W-1:0]        reg_wdata,
   input logic [CNT_W-1:0]        limit,
   input logic [CNT_W+FRAC_W-1:0] cnt,
   input logic                    active,
   input logic                    expire,
   input logic                    to_stat,
   input logic                    raw,
   input logic                    abort_req
);
   a_r2_expire_flags: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> (raw && to_stat));

   a_r3_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (start_evt && !stop_evt && limit < CNT_W'(MIN_LIM)) |=> !active);

   a_r4_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_tick && !start_evt && !stop_evt) |=> $stable(cnt));

   a_r6_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
      stop_evt |=> !to_stat);

   a_r7_abort_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
      abort_req |-> to_stat);

   generate
      if (ABORT_REG) begin : g_reg
         a_r7_bus_held: assert property (@(posedge clk) disable iff (!rst_n)
            (!scl_in || !sda_in) |=> !abort_req);
      end else begin : g_comb
         a_r7_bus_held: assert property (@(posedge clk) disable iff (!rst_n)
            (!scl_in || !sda_in) |-> !abort_req);
      end
   endgenerate

   a_r8_raw_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(2) && reg_wdata[0] && !expire) |=> !raw);

   a_r12_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (start_evt && !stop_evt) |=> cnt == {$past(limit), {FRAC_W{1'b0}}});
endmodule

bind ckto_monitor ckto_monitor_chk #(
   .CNT_W(CNT_W), .FRAC_W(FRAC_W), .MIN_LIM(MIN_LIM), .ADDR_W(ADDR_W), .ABORT_REG(ABORT_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
   .bit_tick(bit_tick), .scl_in(scl_in), .sda_in(sda_in), .reg_wr(reg_wr),
   .reg_addr(reg_addr), .reg_wdata(reg_wdata), .limit(limit), .cnt(cnt),
   .active(active), .expire(expire), .to_stat(to_stat), .raw(raw), .abort_req(abort_req)
);

// File: tb/sim_ckto_monitor.sv
`timescale 1ns/1ps
module sim_ckto_monitor;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [2:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       start_evt = 1'b0, stop_evt = 1'b0, bit_tick = 1'b0;
   logic       scl_in = 1'b1, sda_in = 1'b1;
   logic       abort_req, irq;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   ckto_monitor u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .start_evt(start_evt),
      .stop_evt(stop_evt), .bit_tick(bit_tick), .scl_in(scl_in), .sda_in(sda_in),
      .abort_req(abort_req), .irq(irq)
   );

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      reg_addr = a;
      #0.5;
      d = reg_rdata;
   endtask

   task automatic pulse_start();
      start_evt = 1'b1; @(negedge clk); start_evt = 1'b0;
   endtask

   task automatic pulse_stop();
      stop_evt = 1'b1; @(negedge clk); stop_evt = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         bit_tick = 1'b1; @(negedge clk);
      end
      bit_tick = 1'b0;
   endtask

   // runs a transaction expecting expiry after n ticks
   task automatic expect_expiry(input string req, input int n);
      logic [7:0] d;
      ticks(n - 1);
      rd(3'd1, d); check(req, d[0], 0);
      ticks(1);
      rd(3'd1, d); check(req, d[0], 1);
      rd(3'd2, d); check(req, d[0], 1);
   endtask

   initial begin
      #700000;
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      for (int a = 0; a < 4; a++) begin
         rd(3'(a), d); check("R11", d, 0);
      end
      check("R11", irq, 0);
      check("R11", abort_req, 0);

      // R1 every limit value writes and reads back before any START
      for (int v = 0; v < 256; v++) begin
         wr(3'd0, 8'(v));
         rd(3'd0, d); check("R1", d, v);
      end

      // R2 + R4 sweep of small limits with SCL held low; R6, R7, R8 around expiry
      for (int lim = 2; lim <= 20; lim++) begin
         wr(3'd0, 8'(lim));
         pulse_start();
         scl_in = 1'b0;
         expect_expiry("R2", lim * 16);
         check("R7", abort_req, 0);
         scl_in = 1'b1; sda_in = 1'b0; #0.5;
         check("R7", abort_req, 0);
         sda_in = 1'b1; #0.5;
         check("R7", abort_req, 1);
         @(negedge clk);
         pulse_stop();
         rd(3'd1, d); check("R6", d[0], 0);
         check("R7", abort_req, 0);
         rd(3'd2, d); check("R6", d[0], 1);
         wr(3'd2, 8'h00);
         rd(3'd2, d); check("R8", d[0], 1);
         wr(3'd2, 8'h01);
         rd(3'd2, d); check("R8", d[0], 0);
      end

      // R2 wide values
      wr(3'd0, 8'hDA); pulse_start(); expect_expiry("R2", 3488); pulse_stop(); wr(3'd2, 8'h01);
      wr(3'd0, 8'hFF); pulse_start(); expect_expiry("R2", 4080); pulse_stop(); wr(3'd2, 8'h01);

      // R3 disabled limits
      for (int lim = 0; lim < 2; lim++) begin
         wr(3'd0, 8'(lim));
         pulse_start();
         rd(3'd1, d); check("R3", d[1], 0);
         ticks(100);
         rd(3'd1, d); check("R3", d[0], 0);
         rd(3'd2, d); check("R3", d[0], 0);
         pulse_stop();
      end

      // R4 idle ticks are not counted
      wr(3'd0, 8'd2);
      ticks(50);
      pulse_start();
      expect_expiry("R4", 32);
      pulse_stop(); wr(3'd2, 8'h01);

      // R5 rewrite mid-transaction takes effect at the next START
      wr(3'd0, 8'd3);
      pulse_start();
      wr(3'd0, 8'd2);
      expect_expiry("R5", 48);
      pulse_stop(); wr(3'd2, 8'h01);
      pulse_start();
      expect_expiry("R5", 32);
      pulse_stop(); wr(3'd2, 8'h01);

      // R12 repeated START reloads
      pulse_start();
      ticks(20);
      pulse_start();
      expect_expiry("R12", 32);

      // R9 irq gating
      check("R9", irq, 0);
      wr(3'd3, 8'h01);
      check("R9", irq, 1);
      wr(3'd3, 8'h00);
      check("R9", irq, 0);
      wr(3'd3, 8'h01);
      wr(3'd2, 8'h01);
      check("R9", irq, 0);
      pulse_stop();

      // R10 bus monitor
      for (int k = 0; k < 4; k++) begin
         scl_in = k[0]; sda_in = k[1];
         rd(3'd4, d); check("R10", d, k);
      end
      scl_in = 1'b1; sda_in = 1'b1;

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule